// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces periodic auto-refresh (CBR) for a DRAM controller. A small prescaler turns the controller clock into a base tick of about 15.6 us. It divides by one count when the memory clock runs at 100 MHz and by a smaller count at 66 MHz. An interval counter then stretches that tick by a power of two, chosen by a 3-bit rate code. Each expired interval raises a request toward the command arbiter. The request stays up until the arbiter acknowledges it. If an interval runs out while the previous request is still waiting, the miss is counted instead of queued.

Refresh pacing runs only while the normal-refresh enable is high and the configuration is legal. A suspend input together with a refresh-type select lets the system put the DRAM into self-refresh. On entry the block issues a single-cycle self-refresh request and holds off CBR pacing until suspend is released. With the CBR type selected, pacing continues through suspend.

Top module: `rfsh_interval_timer`

## Requirements
- R1: With a legal configuration and refresh enabled, rate code k in 1..5 (binary 001..101) produces one request every BASE x 2^(k-1) clock cycles, where BASE is the prescaler divisor in use. Rate code 000 produces no requests and clears any pending one.
- R2: Frequency select 2'b00 (100 MHz) uses divisor DIV_FAST. Frequency select 2'b10 (66 MHz) uses divisor DIV_SLOW.
- R3: While refresh_en is 0, no request is raised and a pending request is dropped on the next clock.
- R4: refresh_req stays high until ack is sampled high. It is low from the clock after that acknowledge, unless a new interval expired in the same cycle.
- R5: An interval that expires while refresh_req is high and ack is low adds one to missed_cnt, which saturates at 15. refresh_req stays a single pending request.
- R6: Any change of rate_code restarts both the prescaler and the interval counter from zero. The first request after a change from 000 to code k appears on the clock BASE x 2^(k-1) + 1 cycles after the cycle of the change.
- R7: Rate codes 110 and 111, and frequency selects 2'b01 and 2'b11, act as refresh disabled: no request is raised and a pending one is cleared. They also set cfg_error, which stays set until reset.
- R8: When suspend and sr_type (1 = self-refresh) both become high, self_refresh_req is high for exactly one cycle. CBR requests are suppressed while both stay high. After release, counting restarts from zero, and the first request comes BASE x 2^(k-1) cycles after the first released cycle.
- R9: With suspend high and sr_type 0 (CBR type), periodic requests continue at the programmed rate and self_refresh_req stays low.
- R10: After reset, refresh_req, self_refresh_req, missed_cnt and cfg_error are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_code | input | 3 | Refresh interval code |
| freq_sel | input | 2 | Memory clock select: 00 = 100 MHz, 10 = 66 MHz |
| refresh_en | input | 1 | Normal refresh enable |
| suspend | input | 1 | System suspend indication |
| sr_type | input | 1 | Suspend refresh type: 1 = self-refresh, 0 = CBR |
| ack | input | 1 | Arbiter acknowledge of refresh_req |
| refresh_req | output | 1 | Pending CBR refresh request |
| self_refresh_req | output | 1 | One-cycle self-refresh entry request |
| missed_cnt | output | 4 | Saturating count of intervals lost to a pending request |
| cfg_error | output | 1 | Sticky flag for a reserved rate or frequency code |

## Verification
The bench measures the exact cycle of the first request for every rate code at both divisors. An off-by-one in the prescaler or in the power-of-two compare therefore shows up as a wrong period, and a swapped divisor shows up as the wrong frequency. It leaves requests unacknowledged so that misses accumulate, and checks that the counter reaches 15 and holds there rather than wrapping to zero. It enters self-refresh suspend and checks three things: the entry pulse lasts exactly one cycle, no CBR request appears during suspend, and counting restarts cleanly on release. Reserved rate and frequency codes are also driven, to confirm they act as disabled and that the error flag stays set.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int RATE_W    = 3;
  localparam int FREQ_W    = 2;
  localparam int MAX_SHIFT = 4;
  localparam int MISS_W    = 4;

  localparam logic [FREQ_W-1:0] FREQ_100 = 2'b00;
  localparam logic [FREQ_W-1:0] FREQ_66  = 2'b10;

  typedef struct packed {
    logic       run;
    logic       bad;
    logic [2:0] shift;
  } rate_dec_t;

  function automatic rate_dec_t decode_rate(input logic [RATE_W-1:0] code);
    rate_dec_t d;
    d.run   = 1'b0;
    d.bad   = 1'b0;
    d.shift = 3'd0;
    case (code)
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5: begin
        d.run   = 1'b1;
        d.shift = code - 3'd1;
      end
      3'd6, 3'd7: d.bad = 1'b1;
      default: d.run = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rit_prescaler.sv
module rit_prescaler #(
  parameter int DIV_FAST = 1560,
  parameter int DIV_SLOW = 1030
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic slow,
  output logic tick
);
  localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int CW      = $clog2(DIV_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
    tick  = run & ~clear & (cnt_q >= lim);
    cnt_d = cnt_q;
    if (clear || !run)  cnt_d = '0;
    else if (tick)      cnt_d = '0;
    else                cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rit_interval.sv
module rit_interval
  import rit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clear,
  input  logic       tick,
  input  logic [2:0] shift,
  output logic       expire
);
  logic [MAX_SHIFT-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim    = MAX_SHIFT'((1 << shift) - 1);
    expire = tick & (cnt_q >= lim);
    cnt_d  = cnt_q;
    if (clear || !run) cnt_d = '0;
    else if (expire)   cnt_d = '0;
    else if (tick)     cnt_d = cnt_q + MAX_SHIFT'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rit_handshake.sv
module rit_handshake
  import rit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              expire,
  input  logic              ack,
  output logic              req,
  output logic [MISS_W-1:0] missed
);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic              req_d;
  logic [MISS_W-1:0] missed_d;
  logic              miss_en;

  always_comb begin
    req_d    = run & (expire | (req & ~ack));
    miss_en  = expire & req & ~ack & (missed != MISS_MAX);
    missed_d = miss_en ? missed + MISS_W'(1) : missed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req    <= 1'b0;
      missed <= '0;
    end else begin
      req <= req_d;
      if (miss_en) missed <= missed_d;
    end
  end
endmodule

// File: rtl/rit_suspend_ctl.sv
module rit_suspend_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic suspend,
  input  logic sr_type,
  output logic hold,
  output logic sr_req
);
  logic in_sr_q, sr_req_d;

  always_comb begin
    hold     = suspend & sr_type;
    sr_req_d = hold & ~in_sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sr_q <= 1'b0;
      sr_req  <= 1'b0;
    end else begin
      in_sr_q <= hold;
      sr_req  <= sr_req_d;
    end
  end
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
  import rit_pkg::*;
#(
  parameter int DIV_FAST = 1560,
  parameter int DIV_SLOW = 1030
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_code,
  input  logic [FREQ_W-1:0] freq_sel,
  input  logic              refresh_en,
  input  logic              suspend,
  input  logic              sr_type,
  input  logic              ack,
  output logic              refresh_req,
  output logic              self_refresh_req,
  output logic [MISS_W-1:0] missed_cnt,
  output logic              cfg_error
);
  rate_dec_t         dec;
  logic              freq_ok, run, restart, hold, tick, expire, err_d;
  logic [RATE_W-1:0] code_q;

  always_comb begin
    dec     = decode_rate(rate_code);
    freq_ok = (freq_sel == FREQ_100) || (freq_sel == FREQ_66);
    run     = dec.run & freq_ok & refresh_en & ~hold;
    restart = (rate_code != code_q);
    err_d   = cfg_error | dec.bad | ~freq_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= '0;
      cfg_error <= 1'b0;
    end else begin
      code_q    <= rate_code;
      cfg_error <= err_d;
    end
  end

  rit_suspend_ctl u_susp (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .sr_type(sr_type),
    .hold(hold), .sr_req(self_refresh_req)
  );

  rit_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(restart),
    .slow(freq_sel[1]), .tick(tick)
  );

  rit_interval u_ivl (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(restart),
    .tick(tick), .shift(dec.shift), .expire(expire)
  );

  rit_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .run(run), .expire(expire), .ack(ack),
    .req(refresh_req), .missed(missed_cnt)
  );
endmodule

// File: rtl/rfsh_interval_timer_chk.sv
module rfsh_interval_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] rate_code,
  input logic [1:0] freq_sel,
  input logic       refresh_en,
  input logic       ack,
  input logic       refresh_req,
  input logic       self_refresh_req,
  input logic [3:0] missed_cnt,
  input logic       cfg_error
);
  assert_miss_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (missed_cnt >= $past(missed_cnt)));

  assert_miss_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_cnt == 4'd15) |=> (missed_cnt == 4'd15));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !ack && refresh_en && rate_code != 3'd0 && rate_code < 3'd6 &&
     !freq_sel[0] && $stable(rate_code)) |=> refresh_req || self_refresh_req);

  assert_disable_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_en |=> !refresh_req);

  assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code >= 3'd6 || freq_sel[0]) |=> (!refresh_req && cfg_error));

  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> cfg_error);

  assert_sr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    self_refresh_req |=> !self_refresh_req);
endmodule

bind rfsh_interval_timer rfsh_interval_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .freq_sel(freq_sel),
  .refresh_en(refresh_en), .ack(ack), .refresh_req(refresh_req),
  .self_refresh_req(self_refresh_req), .missed_cnt(missed_cnt),
  .cfg_error(cfg_error)
);

// File: tb/rfsh_interval_timer_bench.sv
module rfsh_interval_timer_bench;
  localparam int DF = 4;
  localparam int DS = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] rate_code;
  logic [1:0] freq_sel;
  logic       refresh_en, suspend, sr_type, ack;
  logic       refresh_req, self_refresh_req, cfg_error;
  logic [3:0] missed_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  rfsh_interval_timer #(.DIV_FAST(DF), .DIV_SLOW(DS)) u_rfsh_interval_timer (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .freq_sel(freq_sel),
    .refresh_en(refresh_en), .suspend(suspend), .sr_type(sr_type), .ack(ack),
    .refresh_req(refresh_req), .self_refresh_req(self_refresh_req),
    .missed_cnt(missed_cnt), .cfg_error(cfg_error)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rate_code = 3'd0; freq_sel = 2'b00; refresh_en = 1'b1;
    suspend = 1'b0; sr_type = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // cycles (negedges after change) until refresh_req rises, capped
  task automatic wait_req(output int k, input int cap);
    k = 0;
    do begin
      @(negedge clk); k++;
    end while (!refresh_req && k < cap);
  endtask

  task automatic ack_once();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic measure(input int code, input logic [1:0] fs, input string tag);
    int k, base;
    rate_code = 3'd0; repeat (2) @(negedge clk);
    freq_sel = fs; rate_code = 3'(code);
    base = fs[1] ? DS : DF;
    wait_req(k, 400);
    check(tag, k, base * (1 << (code - 1)) + 1);
    ack_once();
    check({tag, " ack clears R4"}, int'(refresh_req), 0);
  endtask

  initial begin
    int k;
    do_reset();
    // R10: reset state
    check("R10 req", int'(refresh_req), 0);
    check("R10 sr", int'(self_refresh_req), 0);
    check("R10 miss", int'(missed_cnt), 0);
    check("R10 err", int'(cfg_error), 0);

    // R1 R2 R6: full sweep of codes and both frequencies
    for (int c = 1; c <= 5; c++) begin
      measure(c, 2'b00, $sformatf("R1 R6 fast code %0d", c));
      measure(c, 2'b10, $sformatf("R2 slow code %0d", c));
    end

    // R1: code 0 disables
    rate_code = 3'd0; wait_req(k, 150);
    check("R1 code0 quiet", int'(refresh_req), 0);

    // R3: enable low
    freq_sel = 2'b00; refresh_en = 1'b0; rate_code = 3'd1;
    wait_req(k, 100);
    check("R3 disabled quiet", int'(refresh_req), 0);
    refresh_en = 1'b1;
    rate_code = 3'd0; @(negedge clk);

    // R5: misses accumulate then saturate
    rate_code = 3'd1; k = 0;
    repeat (3 * DF + 1) begin @(negedge clk); k++; end
    check("R5 req pending", int'(refresh_req), 1);
    check("R5 two misses", int'(missed_cnt), 2);
    repeat (20 * DF) @(negedge clk);
    check("R5 saturate", int'(missed_cnt), 15);
    check("R5 single req", int'(refresh_req), 1);
    ack_once();

    // R9: suspend with CBR type keeps pacing
    rate_code = 3'd0; repeat (2) @(negedge clk);
    suspend = 1'b1; sr_type = 1'b0; rate_code = 3'd2;
    wait_req(k, 200);
    check("R9 cbr in suspend", k, DF * 2 + 1);
    check("R9 no sr", int'(self_refresh_req), 0);
    ack_once();
    suspend = 1'b0;

    // R8: self-refresh entry
    sr_type = 1'b1; suspend = 1'b1;
    @(negedge clk);
    check("R8 sr pulse", int'(self_refresh_req), 1);
    @(negedge clk);
    check("R8 sr one cycle", int'(self_refresh_req), 0);
    wait_req(k, 100);
    check("R8 cbr suppressed", int'(refresh_req), 0);
    suspend = 1'b0;
    wait_req(k, 200);
    check("R8 restart after release", k, DF * 2);
    ack_once();

    // R7: reserved rate
    rate_code = 3'd6; wait_req(k, 100);
    check("R7 rate reserved quiet", int'(refresh_req), 0);
    check("R7 err set", int'(cfg_error), 1);
    rate_code = 3'd1; @(negedge clk);
    check("R7 err sticky", int'(cfg_error), 1);

    // R7: reserved frequency after fresh reset
    do_reset();
    refresh_en = 1'b1; freq_sel = 2'b01; rate_code = 3'd1;
    wait_req(k, 100);
    check("R7 freq reserved quiet", int'(refresh_req), 0);
    check("R7 freq err", int'(cfg_error), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule